// File: doc/BRIEF.md
# Dual-Port Interrupt Pin Controller

This block sits between the change-detection logic of a two-port 8-bit I/O expander and its two interrupt pins. Each port has its own change event. When a port has no interrupt pending, an event makes one pending and stores that port's pin values in a capture register. The interrupt stays pending until the host makes the clearing read. A configuration bit chooses the clearing read: either the read of the port's capture register or the read of its data register.

The pending state of each port drives one pin. A mirror option ORs the two ports so that both pins follow either port. Each pin runs push-pull, with a selectable active level, or open-drain. In open-drain mode the pin can only pull low or float. The outputs are a drive value and an output-enable per pin, which feed a pad outside this block.

The configuration inputs are registered, and reset clears them. After reset both pins are therefore inactive, in push-pull mode, with active-low drive.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset no port has an interrupt pending, both capture registers read 0x00, and both pins are inactive in push-pull active-low mode: `int_oe` = 2'b11 and `int_drv` = 2'b11.
- R2: `cfg_*` inputs are sampled at each rising clock edge. The pins respond to a configuration change only after the edge that samples it.
- R3: An event on a port with no interrupt pending makes the interrupt pending at the next rising edge. At that same edge the port's current pin values are stored in its capture register.
- R4: While a port's interrupt is pending, further events and pin changes leave its capture register unchanged.
- R5: With `cfg_clr_cap` = 1, a port's pending interrupt is cleared at the edge where that port's capture read strobe is high. Its data read strobe has no effect.
- R6: With `cfg_clr_cap` = 0, a port's pending interrupt is cleared at the edge where that port's data read strobe is high. Its capture read strobe has no effect.
- R7: A clearing read and an event in the same cycle clear the pending interrupt at that edge. The interrupt becomes pending again one edge later, and the pin values present at that second edge are stored in the capture register.
- R8: With `cfg_mirror` = 0, pin A (bit 0) follows port A only and pin B (bit 1) follows port B only. With `cfg_mirror` = 1, both pins are active when either port has an interrupt pending.
- R9: With `cfg_od` = 0, `int_oe` is 1 for the pin. `int_drv` equals the pin's active state when `cfg_pol` = 1 and the inverse of that state when `cfg_pol` = 0.
- R10: With `cfg_od` = 1, a pin's `int_oe` is 1 only while the pin is active, and `int_drv` is 0. `cfg_pol` has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_a | input | 1 | Change event, port A |
| evt_b | input | 1 | Change event, port B |
| pins_a | input | 8 | Current pin values, port A |
| pins_b | input | 8 | Current pin values, port B |
| rd_cap_a | input | 1 | Capture register read strobe, port A |
| rd_cap_b | input | 1 | Capture register read strobe, port B |
| rd_dat_a | input | 1 | Data register read strobe, port A |
| rd_dat_b | input | 1 | Data register read strobe, port B |
| cfg_mirror | input | 1 | 1: OR both ports onto both pins |
| cfg_od | input | 1 | 1: open-drain pins |
| cfg_pol | input | 1 | 1: active-high push-pull drive |
| cfg_clr_cap | input | 1 | 1: capture read clears; 0: data read clears |
| int_drv | output | 2 | Pin drive value (bit 0 pin A, bit 1 pin B) |
| int_oe | output | 2 | Pin output-enable (bit 0 pin A, bit 1 pin B) |
| cap_a | output | 8 | Captured pin values, port A |
| cap_b | output | 8 | Captured pin values, port B |

## Verification
The hardest case to reach is a clearing read that arrives in the same cycle as a new event. The pin has to drop for exactly one cycle, and the capture must then take the pin values from the following cycle rather than the values present during the read. The directed stimulus first makes port B pending. It then raises the capture read and the event together while the pins hold one value, and changes the pins before the next edge. A capture that took the wrong cycle's values, or a pin that never dropped, therefore shows up at the ports. A table of mirror, drive-mode and polarity combinations walks every pin-stage outcome, with the port pending states set up through real events and cleared through real reads.

// File: rtl/irq_out_pkg.sv
package irq_out_pkg;

  localparam int unsigned NUM_PORTS = 2;

  typedef struct packed {
    logic oe;
    logic drv;
  } pin_out_t;

  // Pad control for one interrupt pin from its active state and mode bits.
  function automatic pin_out_t pin_drive(input logic active, input logic od,
                                         input logic pol);
    pin_out_t r;
    if (od) begin
      r.oe  = active;
      r.drv = 1'b0;
    end else begin
      r.oe  = 1'b1;
      r.drv = pol ? active : ~active;
    end
    return r;
  endfunction

  // Pin activity per port after optional mirroring.
  function automatic logic [NUM_PORTS-1:0] mirror_map(
      input logic [NUM_PORTS-1:0] pend, input logic mirror);
    return mirror ? {NUM_PORTS{|pend}} : pend;
  endfunction

endpackage

// File: rtl/irq_pend_port.sv
module irq_pend_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] pins,
  input  logic         rd_cap,
  input  logic         rd_dat,
  input  logic         clr_on_cap,
  output logic         pending,
  output logic [W-1:0] cap
);

  logic         pend_q;
  logic [W-1:0] cap_q;
  logic         repend_q;

  // Named internal events for the assertions.
  logic clr_hit;
  logic take;

  assign clr_hit = pend_q && (clr_on_cap ? rd_cap : rd_dat);
  assign take    = !pend_q && !clr_hit && (evt || repend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cap_q    <= '0;
      repend_q <= 1'b0;
    end else begin
      repend_q <= clr_hit && evt;
      if (clr_hit) begin
        pend_q <= 1'b0;
      end else if (take) begin
        pend_q <= 1'b1;
        cap_q  <= pins;
      end
    end
  end

  assign pending = pend_q;
  assign cap     = cap_q;

  AST_CAPTURE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pend_q && cap_q == $past(pins))); // R3

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_hit) |=> (pend_q && $stable(cap_q))); // R4

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !evt) |=> !pend_q); // R5

  AST_CLEAR_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !evt && (clr_on_cap ? !rd_cap : !rd_dat)) |=> pend_q); // R6

  AST_REPEND_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && evt) |=> (!pend_q ##1 pend_q)); // R7

endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_out_pkg::*;
(
  input  logic active,
  input  logic od,
  input  logic pol,
  output logic drv,
  output logic oe
);

  pin_out_t po;

  always_comb begin
    po  = pin_drive(active, od, pol);
    drv = po.drv;
    oe  = po.oe;
  end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_out_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_a,
  input  logic              evt_b,
  input  logic [PORT_W-1:0] pins_a,
  input  logic [PORT_W-1:0] pins_b,
  input  logic              rd_cap_a,
  input  logic              rd_cap_b,
  input  logic              rd_dat_a,
  input  logic              rd_dat_b,
  input  logic              cfg_mirror,
  input  logic              cfg_od,
  input  logic              cfg_pol,
  input  logic              cfg_clr_cap,
  output logic [1:0]        int_drv,
  output logic [1:0]        int_oe,
  output logic [PORT_W-1:0] cap_a,
  output logic [PORT_W-1:0] cap_b
);

  localparam int unsigned NP = NUM_PORTS;

  // Registered configuration, cleared by reset.
  logic mirror_q, od_q, pol_q, clr_cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q  <= 1'b0;
      od_q      <= 1'b0;
      pol_q     <= 1'b0;
      clr_cap_q <= 1'b0;
    end else begin
      mirror_q  <= cfg_mirror;
      od_q      <= cfg_od;
      pol_q     <= cfg_pol;
      clr_cap_q <= cfg_clr_cap;
    end
  end

  logic [NP-1:0]             evt_v, rd_cap_v, rd_dat_v, pend_v, active_v;
  logic [NP-1:0]             drv_v, oe_v;
  logic [NP-1:0][PORT_W-1:0] pins_v, cap_v;

  assign evt_v    = {evt_b, evt_a};
  assign rd_cap_v = {rd_cap_b, rd_cap_a};
  assign rd_dat_v = {rd_dat_b, rd_dat_a};
  assign pins_v   = {pins_b, pins_a};

  for (genvar p = 0; p < NP; p++) begin : g_port
    irq_pend_port #(.W(PORT_W)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt_v[p]),
      .pins       (pins_v[p]),
      .rd_cap     (rd_cap_v[p]),
      .rd_dat     (rd_dat_v[p]),
      .clr_on_cap (clr_cap_q),
      .pending    (pend_v[p]),
      .cap        (cap_v[p])
    );

    irq_pin_stage u_pin (
      .active (active_v[p]),
      .od     (od_q),
      .pol    (pol_q),
      .drv    (drv_v[p]),
      .oe     (oe_v[p])
    );
  end

  assign active_v = mirror_map(pend_v, mirror_q);

  assign int_drv = drv_v;
  assign int_oe  = oe_v;
  assign cap_a   = cap_v[0];
  assign cap_b   = cap_v[1];

  AST_MIRROR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_q && (|pend_v)) |-> (active_v == 2'b11)); // R8

  AST_SEPARATE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !mirror_q |-> (active_v == pend_v)); // R8

  AST_PUSHPULL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !od_q |-> (int_oe == 2'b11)); // R9

  AST_OPEN_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q && !(|pend_v)) |-> (int_oe == 2'b00 && int_drv == 2'b00)); // R10

  AST_CFG_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cfg_pol) |=> (pol_q == $past(cfg_pol))); // R2

endmodule

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_a, evt_b;
  logic [7:0] pins_a, pins_b;
  logic       rd_cap_a, rd_cap_b, rd_dat_a, rd_dat_b;
  logic       cfg_mirror, cfg_od, cfg_pol, cfg_clr_cap;
  logic [1:0] int_drv, int_oe;
  logic [7:0] cap_a, cap_b;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_pin_ctrl u_irq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
    .pins_a(pins_a), .pins_b(pins_b),
    .rd_cap_a(rd_cap_a), .rd_cap_b(rd_cap_b),
    .rd_dat_a(rd_dat_a), .rd_dat_b(rd_dat_b),
    .cfg_mirror(cfg_mirror), .cfg_od(cfg_od), .cfg_pol(cfg_pol),
    .cfg_clr_cap(cfg_clr_cap),
    .int_drv(int_drv), .int_oe(int_oe), .cap_a(cap_a), .cap_b(cap_b)
  );

  // Vector: {mirror, od, pol, pend_a, pend_b, drv[1:0], oe[1:0]}, bit 0 = pin A.
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    9'b00000_11_11,
    9'b00010_10_11,
    9'b00110_01_11,
    9'b10110_11_11,
    9'b10001_00_11,
    9'b01101_00_10,
    9'b11010_00_11,
    9'b01000_00_00,
    9'b01111_00_11
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    evt_a = 0; evt_b = 0;
    rd_cap_a = 0; rd_cap_b = 0; rd_dat_a = 0; rd_dat_b = 0;
  endtask

  // Clear both ports through the data reads (clear control must be 0).
  task automatic clear_by_data();
    @(negedge clk);
    rd_dat_a = 1; rd_dat_b = 1;
    edge_step();
    idle_inputs();
  endtask

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    pins_a = 8'h00; pins_b = 8'h00;
    cfg_mirror = 0; cfg_od = 0; cfg_pol = 0; cfg_clr_cap = 0;
    repeat (3) edge_step();
    @(negedge clk);
    rst_n = 1;
    edge_step();

    // R1 reset state
    check("R1 int_oe", {6'd0, int_oe}, 8'h03);
    check("R1 int_drv", {6'd0, int_drv}, 8'h03);
    check("R1 cap_a", cap_a, 8'h00);
    check("R1 cap_b", cap_b, 8'h00);

    // Table walk: R8 mirror, R9 push-pull, R10 open-drain
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      cfg_clr_cap = 0;
      clear_by_data();
      @(negedge clk);
      cfg_mirror = v[8]; cfg_od = v[7]; cfg_pol = v[6];
      evt_a = v[5]; evt_b = v[4];
      edge_step();
      idle_inputs();
      check($sformatf("R8/R9/R10 vec%0d int_drv", i), {6'd0, int_drv}, {6'd0, v[3:2]});
      check($sformatf("R8/R9/R10 vec%0d int_oe", i), {6'd0, int_oe}, {6'd0, v[1:0]});
    end

    // Directed: push-pull, active-low, separate pins, data read clears
    @(negedge clk);
    cfg_mirror = 0; cfg_od = 0; cfg_pol = 0; cfg_clr_cap = 0;
    edge_step();
    clear_by_data();
    check("R6 cleared baseline", {6'd0, int_drv}, 8'h03);

    // R3 capture on first event
    @(negedge clk);
    pins_a = 8'h5A; evt_a = 1;
    edge_step();
    idle_inputs();
    check("R3 cap_a", cap_a, 8'h5A);
    check("R3 pin A active", {6'd0, int_drv}, 8'h02);

    // R4 later event does not overwrite
    @(negedge clk);
    pins_a = 8'h33; evt_a = 1;
    edge_step();
    idle_inputs();
    check("R4 cap_a held", cap_a, 8'h5A);

    // R6 capture read ignored, data read clears
    @(negedge clk);
    rd_cap_a = 1;
    edge_step();
    idle_inputs();
    check("R6 capture read ignored", {6'd0, int_drv}, 8'h02);
    @(negedge clk);
    rd_dat_a = 1;
    edge_step();
    idle_inputs();
    check("R6 data read clears", {6'd0, int_drv}, 8'h03);

    // R5 capture read clears when clear control is 1
    @(negedge clk);
    cfg_clr_cap = 1; pins_a = 8'h11; evt_a = 1;
    edge_step();
    idle_inputs();
    check("R5 cap_a", cap_a, 8'h11);
    @(negedge clk);
    rd_dat_a = 1;
    edge_step();
    idle_inputs();
    check("R5 data read ignored", {6'd0, int_drv}, 8'h02);
    @(negedge clk);
    rd_cap_a = 1;
    edge_step();
    idle_inputs();
    check("R5 capture read clears", {6'd0, int_drv}, 8'h03);

    // R7 clearing read and event in one cycle on port B
    @(negedge clk);
    pins_b = 8'hC3; evt_b = 1;
    edge_step();
    idle_inputs();
    check("R7 first capture", cap_b, 8'hC3);
    @(negedge clk);
    pins_b = 8'h7E; rd_cap_b = 1; evt_b = 1;
    edge_step();
    idle_inputs();
    check("R7 cleared for one cycle", {6'd0, int_drv}, 8'h03);
    check("R7 capture kept", cap_b, 8'hC3);
    @(negedge clk);
    pins_b = 8'h81;
    edge_step();
    check("R7 re-pended", {6'd0, int_drv}, 8'h01);
    check("R7 recapture", cap_b, 8'h81);

    // R2 configuration acts only after the sampling edge
    @(negedge clk);
    cfg_pol = 1;
    #2;
    check("R2 before edge", {6'd0, int_drv}, 8'h01);
    edge_step();
    check("R2 after edge", {6'd0, int_drv}, 8'h02);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule